// File: doc/BRIEF.md
# Chip-Select Wait-State Access Sequencer

This block carries single read or write requests from an on-chip request port out to one of four external memory devices, each behind its own active-low chip select. The target device is picked by two bits of the request address. Every chip select has its own configuration, supplied on static inputs:

- a 4-bit wait code that sets how long an access lasts;
- a write-permission bit;
- a 2-bit data-width code.

An accepted request turns into a fixed-length strobe sequence on the memory side. The chip select is held for the whole access. Output enable or write enable is asserted from the second cycle onward. Read data is captured on the last cycle. A one-cycle done pulse, with an error flag, reports the end of the access. A write to a chip select that has no write permission never reaches the pins. It ends at once with the error flag set.

Only the low byte lanes that the configured width covers are driven on writes or returned on reads. The remaining lanes read as zero. The configuration inputs must stay stable while an access is in flight.

Top module: `cs_access_seq`

## Requirements
- R1: A wait code n from 0 to 13 makes a permitted access hold its chip select low for exactly n+2 consecutive cycles. `rsp_done` pulses high for one cycle in the cycle after the last of these.
- R2: Wait codes 14 and 15 both make the access last exactly 16 cycles.
- R3: The chip select is chosen by `req_addr[27:26]`. Value k drives `mem_cs_n` bit k low and every other bit high. All bits are high when no access is in progress. Each access uses the wait code, permission and width of its own chip select, taken from nibble k of `cfg_wait`, bit k of `cfg_wr_ok` and field `cfg_width[2k+1:2k]`.
- R4: `req_ready` is high when idle, including during reset and in the done cycle. It is low in every cycle of an access. A request is taken when `req_valid` and `req_ready` are both high at a rising edge.
- R5: On a read, `mem_oe_n` is low from the second cycle of the access through the last cycle, and `mem_we_n` stays high. On a write, `mem_we_n` is low over the same cycles and `mem_oe_n` stays high. Both strobes are high in the first cycle and when idle.
- R6: A write to a chip select whose permission bit is 0 asserts no chip select and no write strobe. `rsp_done` and `rsp_err` are both high in the cycle right after acceptance. Reads to that chip select proceed normally.
- R7: Width code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. During a write, `mem_wdata` carries only the covered low byte lanes of `req_wdata` and zero above them. `mem_lane_en` has one bit per covered lane and is zero when idle.
- R8: On a read, `rsp_rdata` in the done cycle equals the `mem_rdata` present in the last access cycle, masked to the covered lanes, with the uncovered lanes zero.
- R9: `rsp_err` is 0 on the completion of every permitted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address; bits 27:26 select the chip select |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a rejected write |
| rsp_rdata | output | 32 | Masked read data, valid with `rsp_done` after a read |
| cfg_wait | input | 16 | Four 4-bit wait codes, nibble k for chip select k |
| cfg_wr_ok | input | 4 | Per-chip-select write permission |
| cfg_width | input | 8 | Four 2-bit width codes |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 32 | Latched access address |
| mem_wdata | output | 32 | Lane-masked write data |
| mem_lane_en | output | 4 | Active byte lanes of the current access |
| mem_rdata | input | 32 | Read data from the memory |

## Verification
The assertions check the properties that hold on every cycle:

- at most one chip select is low at a time;
- the two strobes are never low together, and never low outside a chip select;
- the chip select holds steady until the last cycle, and the cycle counter stays within the decoded length;
- a rejected write completes with an error on the next cycle;
- the write strobe never falls while the permission of the current chip select is off.

The exact access length for each wait code, including the saturation of the two top codes, is shown only by the bench's scenarios. The same holds for the cycle on which read data is sampled, the byte-lane masking for each width code, and the claim that a read to a write-protected chip select still runs normally.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  localparam logic [1:0] WID_8  = 2'd0;
  localparam logic [1:0] WID_16 = 2'd1;

  localparam int LEN_W = 5;

  // Decoded access length in cycles: code + 2, saturating at 16
  function automatic logic [LEN_W-1:0] access_len(input logic [3:0] code);
    logic [LEN_W-1:0] len;
    if (code >= 4'd14) len = 5'd16;
    else               len = {1'b0, code} + 5'd2;
    return len;
  endfunction

endpackage

// File: rtl/cs_cfg_select.sv
module cs_cfg_select
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int LANES  = 4
) (
  input  logic [CS_W-1:0]     sel,
  input  logic [NUM_CS*4-1:0] cfg_wait,
  input  logic [NUM_CS-1:0]   cfg_wr_ok,
  input  logic [NUM_CS*2-1:0] cfg_width,
  output logic [LEN_W-1:0]    len,
  output logic                wr_ok,
  output logic [LANES-1:0]    lane_en
);

  logic [3:0] wait_a  [NUM_CS];
  logic [1:0] width_a [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign wait_a[g]  = cfg_wait[4*g +: 4];
    assign width_a[g] = cfg_width[2*g +: 2];
  end

  int n_lanes;

  always_comb begin
    len   = access_len(wait_a[sel]);
    wr_ok = cfg_wr_ok[sel];
    case (width_a[sel])
      WID_8:   n_lanes = 1;
      WID_16:  n_lanes = 2;
      default: n_lanes = LANES;
    endcase
    for (int i = 0; i < LANES; i++) begin
      lane_en[i] = (i < n_lanes);
    end
  end

endmodule

// File: rtl/cs_wait_counter.sv
module cs_wait_counter
  import cs_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] cnt,
  output logic             last
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last = busy && (cnt_q == len_i);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = 5'd1;
    end else if (busy && !last) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R1: the running count never leaves 1..length during an access
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q >= 5'd1 && cnt_q <= len_i));

endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic             busy,
  input  logic [LEN_W-1:0] cnt,
  input  logic             write,
  input  logic [CS_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n,
  output logic             oe_n,
  output logic             we_n
);

  logic strobe_on;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(busy && (sel == CS_W'(g)));
  end

  assign strobe_on = busy && (cnt >= 5'd2);
  assign oe_n      = !(strobe_on && !write);
  assign we_n      = !(strobe_on && write);

endmodule

// File: rtl/cs_lane_mask.sv
module cs_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   lane_en,
  output logic [LANES*8-1:0] data_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[8*g +: 8] = lane_en[g] ? data_i[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/cs_access_seq.sv
module cs_access_seq
  import cs_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int CS_LSB = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_CS*4-1:0] cfg_wait,
  input  logic [NUM_CS-1:0]   cfg_wr_ok,
  input  logic [NUM_CS*2-1:0] cfg_width,
  output logic [NUM_CS-1:0]   mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_lane_en,
  input  logic [DATA_W-1:0]   mem_rdata
);

  localparam int CS_W  = $clog2(NUM_CS);
  localparam int LANES = DATA_W / 8;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // State and request decode
  seq_state_e        state_q, state_d;
  logic              busy, accept, blocked, start, last;
  logic [CS_W-1:0]   sel_now;
  logic [LEN_W-1:0]  len_now;
  logic              wr_ok_now;
  logic [LANES-1:0]  lanes_now;
  logic [DATA_W-1:0] wdata_masked, rdata_masked;
  logic [LEN_W-1:0]  cnt;

  logic              write_q;
  logic [CS_W-1:0]   sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lanes_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  assign busy      = (state_q == SEQ_BUSY);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign sel_now   = req_addr[CS_LSB +: CS_W];
  assign blocked   = accept && req_write && !wr_ok_now;
  assign start     = accept && !blocked;

  cs_cfg_select #(.NUM_CS(NUM_CS), .CS_W(CS_W), .LANES(LANES)) u_cfg (
    .sel       (sel_now),
    .cfg_wait  (cfg_wait),
    .cfg_wr_ok (cfg_wr_ok),
    .cfg_width (cfg_width),
    .len       (len_now),
    .wr_ok     (wr_ok_now),
    .lane_en   (lanes_now)
  );

  cs_lane_mask #(.LANES(LANES)) u_wmask (
    .data_i  (req_wdata),
    .lane_en (lanes_now),
    .data_o  (wdata_masked)
  );

  cs_lane_mask #(.LANES(LANES)) u_rmask (
    .data_i  (mem_rdata),
    .lane_en (lanes_q),
    .data_o  (rdata_masked)
  );

  cs_wait_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .busy  (busy),
    .len_i (len_q),
    .cnt   (cnt),
    .last  (last)
  );

  cs_strobe_gen #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_strobe (
    .busy  (busy),
    .cnt   (cnt),
    .write (write_q),
    .sel   (sel_q),
    .cs_n  (mem_cs_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_BUSY;
      SEQ_BUSY: if (last)  state_d = SEQ_IDLE;
      default:             state_d = SEQ_IDLE;
    endcase
    done_d   = blocked || last;
    err_d    = blocked;
    rdata_en = last && !write_q;
    rdata_d  = rdata_masked;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // Request capture, enabled by start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      write_q <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
      len_q   <= 5'd2;
    end else if (start) begin
      write_q <= req_write;
      sel_q   <= sel_now;
      addr_q  <= req_addr;
      wdata_q <= wdata_masked;
      lanes_q <= lanes_now;
      len_q   <= len_now;
    end
  end

  // Read data capture, enabled on the last cycle of a read
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rsp_done    = done_q;
  assign rsp_err     = err_q;
  assign rsp_rdata   = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_lane_en = busy ? lanes_q : '0;

  // R3: never more than one chip select active
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(~mem_cs_n));

  // R5: read and write strobes are mutually exclusive
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!mem_oe_n && !mem_we_n));

  // R5: a strobe only ever sits inside an active chip select
  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  // R1: the chip select does not move before the last cycle
  p_cs_held_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !last) |=> (mem_cs_n == $past(mem_cs_n)));

  // R1: the last cycle is followed by the done pulse
  p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    last |=> (rsp_done && !rsp_err));

  // R6: a rejected write ends at once with an error and no select
  p_blocked_resp_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    blocked |=> (rsp_done && rsp_err && (&mem_cs_n) && mem_we_n));

  // R6: the write strobe is never asserted for a protected chip select
  p_we_permitted_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_we_n |-> cfg_wr_ok[sel_q]);

  // R4: a taken request drops ready on the next cycle
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> !req_ready);

  // R9: an error is only ever reported with a completion
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_err |-> rsp_done);

endmodule

// File: tb/cs_access_seq_bench.sv
`timescale 1ns/1ps
module cs_access_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [15:0] cfg_wait;
  logic [3:0]  cfg_wr_ok;
  logic [7:0]  cfg_width;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_lane_en;
  logic [31:0] mem_rdata;

  logic [3:0] wcode [4];
  logic       wok   [4];
  logic [1:0] wid   [4];

  int n_chk;
  int n_fail;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      cfg_wait[4*i +: 4]  = wcode[i];
      cfg_wr_ok[i]        = wok[i];
      cfg_width[2*i +: 2] = wid[i];
    end
  end

  cs_access_seq u_cs_access_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_wait(cfg_wait), .cfg_wr_ok(cfg_wr_ok), .cfg_width(cfg_width),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_lane_en(mem_lane_en),
    .mem_rdata(mem_rdata)
  );

  function automatic int exp_len(input logic [3:0] code);
    return (code >= 4'd14) ? 16 : int'(code) + 2;
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [1:0] w);
    case (w)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_mask(input logic [1:0] w);
    logic [3:0]  l = exp_lanes(w);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = l[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input bit wr, input logic [1:0] cs, input logic [31:0] wd);
    logic [31:0] addr;
    logic [31:0] last_rd;
    logic [31:0] mask;
    logic [3:0]  cs_exp;
    int          len;
    string       len_tag;
    addr        = $urandom;
    addr[27:26] = cs;
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && !wok[cs]) begin
      chk(rsp_done == 1'b1, "R6 blocked done", {31'd0, rsp_done}, 32'd1);
      chk(rsp_err == 1'b1, "R6 blocked err", {31'd0, rsp_err}, 32'd1);
      chk(mem_cs_n == 4'hF, "R6 blocked no cs", {28'd0, mem_cs_n}, 32'hF);
      chk(mem_we_n == 1'b1, "R6 blocked no we", {31'd0, mem_we_n}, 32'd1);
      return;
    end
    len     = exp_len(wcode[cs]);
    len_tag = (wcode[cs] >= 4'd14) ? "R2 length" : "R1 length";
    mask    = exp_mask(wid[cs]);
    cs_exp  = ~(4'b0001 << cs);
    last_rd = '0;
    for (int k = 1; k <= len; k++) begin
      mem_rdata = $urandom;
      if (k == len) last_rd = mem_rdata;
      chk(mem_cs_n == cs_exp, "R3 cs select", {28'd0, mem_cs_n}, {28'd0, cs_exp});
      chk(mem_oe_n == !(!wr && k >= 2), "R5 oe_n",
          {31'd0, mem_oe_n}, {31'd0, !(!wr && k >= 2)});
      chk(mem_we_n == !(wr && k >= 2), "R5 we_n",
          {31'd0, mem_we_n}, {31'd0, !(wr && k >= 2)});
      chk(req_ready == 1'b0, "R4 ready busy", {31'd0, req_ready}, 32'd0);
      chk(rsp_done == 1'b0, len_tag, {31'd0, rsp_done}, 32'd0);
      chk(mem_lane_en == exp_lanes(wid[cs]), "R7 lane_en",
          {28'd0, mem_lane_en}, {28'd0, exp_lanes(wid[cs])});
      if (wr) chk(mem_wdata == (wd & mask), "R7 wdata", mem_wdata, wd & mask);
      @(negedge clk);
    end
    chk(rsp_done == 1'b1, len_tag, {31'd0, rsp_done}, 32'd1);
    chk(rsp_err == 1'b0, "R9 err clear", {31'd0, rsp_err}, 32'd0);
    chk(mem_cs_n == 4'hF, "R3 cs idle", {28'd0, mem_cs_n}, 32'hF);
    chk(req_ready == 1'b1, "R4 ready done", {31'd0, req_ready}, 32'd1);
    chk(mem_lane_en == 4'h0, "R7 lane_en idle", {28'd0, mem_lane_en}, 32'd0);
    if (!wr) chk(rsp_rdata == (last_rd & mask), "R8 rdata", rsp_rdata, last_rd & mask);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #400us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    mem_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      wcode[i] = 4'd0;
      wok[i]   = 1'b1;
      wid[i]   = 2'd2;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R4 reset ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_done == 1'b0, "R1 reset done", {31'd0, rsp_done}, 32'd0);
    chk(mem_cs_n == 4'hF, "R3 reset cs", {28'd0, mem_cs_n}, 32'hF);
    chk(mem_oe_n && mem_we_n, "R5 reset strobes", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R2: every wait code, reads on chip select 0
    for (int c = 0; c < 16; c++) begin
      wcode[0] = 4'(c);
      run_access(1'b0, 2'd0, 32'h0);
    end
    // R2: the saturating codes as writes too
    wcode[1] = 4'd14; run_access(1'b1, 2'd1, 32'hA5A5_1234);
    wcode[1] = 4'd15; run_access(1'b1, 2'd1, 32'h5A5A_4321);

    // R7 and R8: each width code on reads and writes
    for (int w = 0; w < 4; w++) begin
      wid[3] = 2'(w);
      wcode[3] = 4'd3;
      run_access(1'b1, 2'd3, 32'hDEAD_BEEF);
      run_access(1'b0, 2'd3, 32'h0);
    end

    // R6: protected chip select rejects writes, still serves reads
    wok[2] = 1'b0;
    wcode[2] = 4'd5;
    run_access(1'b1, 2'd2, 32'hCAFE_F00D);
    run_access(1'b0, 2'd2, 32'h0);
    run_access(1'b1, 2'd2, 32'h1111_2222);
    wok[2] = 1'b1;
    run_access(1'b1, 2'd2, 32'h3333_4444);

    // R3: random configuration and traffic over all chip selects
    for (int n = 0; n < 300; n++) begin
      if (n % 10 == 0) begin
        for (int i = 0; i < 4; i++) begin
          wcode[i] = 4'($urandom_range(0, 15));
          wok[i]   = 1'($urandom_range(0, 1));
          wid[i]   = 2'($urandom_range(0, 3));
        end
      end
      run_access(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom);
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule